// File: doc/BRIEF.md
# SPI Port with Select-Line Fault Guard

This block is a byte-wide SPI port that works either as the clock-driving master or as a selected slave. Transfers use clock mode 0 only and go most significant bit first. Software reaches it through a small register bus with four byte registers: control, status, data and a pad register. When the master side is enabled, a write to the data register starts a byte. In slave mode, a write while the port is not receiving preloads the next reply byte. The last received byte stays in a read buffer while the next one shifts.

The active-low select pad has one of four roles, and the role depends on the mode and on two control bits:

- **Slave mode:** the pad is the select input.
- **Master mode, fault checking on:** the pad is watched for another master pulling it low. If that happens, the port drops out of master mode, disables itself and raises a fault flag.
- **Master mode, fault checking off, drive bit set:** the port drives the pad low for the length of each byte and high when idle.
- **Master mode, fault checking off, drive bit clear:** the pad is handed to software through the pad register.

A data write that arrives while a byte is moving is rejected. It sets a sticky collision flag and leaves the moving byte untouched. One interrupt line merges the completion flag and the fault flag.

Register map:

| Address | Register | Bits |
|---|---|---|
| 0 | Control | 7 select-drive, 6 enable, 5 interrupt enable, 4 master; bits 3:0 read 0 |
| 1 | Status | 7 done, 6 collision, 4 fault, 3 fault-check-off |
| 2 | Data | write: byte to send; read: receive buffer |
| 3 | Pad | 1 pad output enable, 0 pad value |

Top module: `spix_top`

## Requirements
- R1: After reset, control, status, pad register and receive buffer read 0x00. ss_oe, sck_oe and irq are 0, and ss_o is 1.
- R2: With control bit 4 (master) clear, ss_oe stays 0 and ss_i alone gates slave shifting. While ss_i is high, SCK edges change neither status nor the receive buffer. While selected, miso_oe is 1.
- R3: In master mode with status bit 3 (fault-check-off) set and control bit 7 (select-drive) set, ss_oe is 1. ss_o is 0 while a byte is moving and 1 while idle.
- R4: In master mode with status bit 3 set and control bit 7 clear, ss_oe follows pad register bit 1 and ss_o follows pad register bit 0.
- R5: An enabled master with status bit 3 clear that sees ss_i low, after a two-flop synchronizer, clears control bit 4 and control bit 6 (enable) and sets status bit 4. With status bit 3 set, ss_i low has no effect.
- R6: irq is a registered output. It is 1 when control bit 5 is set, irq_global_en is 1, and status bit 7 or status bit 4 is set.
- R7: A master byte presents its bits on mosi_o MSB first, changing on the falling SCK edge. miso_i is sampled on the rising edge. After the eighth bit, status bit 7 is set and address 2 reads the received byte.
- R8: A data write during a master byte sets status bit 6. The byte in progress completes unchanged and the written byte is discarded.
- R9: In slave mode, a data write while a byte is being received sets status bit 6. A data write while idle sets no flag and becomes the next byte on miso_o, MSB first.
- R10: Status bits 7, 6 and 4 are cleared only by writing 1 to that bit of the status register. Writing 0 there leaves them set, and hardware never clears them.
- R11: bus_rdata holds the addressed register value in the cycle after bus_rd is sampled.
- R12: A selected slave shifts in eight mosi_i bits, sampled on the rising SCK edges. It then sets status bit 7 and exposes the byte at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after bus_rd |
| irq_global_en | input | 1 | System-level interrupt gate |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | SCK pad input (slave) |
| sck_o | output | 1 | SCK pad output (master) |
| sck_oe | output | 1 | SCK pad drive enable |
| mosi_i | input | 1 | MOSI pad input (slave) |
| mosi_o | output | 1 | MOSI pad output (master) |
| mosi_oe | output | 1 | MOSI pad drive enable |
| miso_i | input | 1 | MISO pad input (master) |
| miso_o | output | 1 | MISO pad output (slave) |
| miso_oe | output | 1 | MISO pad drive enable |
| ss_i | input | 1 | Select pad input, active low |
| ss_o | output | 1 | Select pad output value |
| ss_oe | output | 1 | Select pad drive enable |

## Verification
The properties assume that SCK, MOSI and select reach the port through the synchronizer and stay stable for several core cycles per level. They also assume the register bus never asserts read and write in the same cycle. The stimulus keeps each slave SCK half-period at eight core cycles and changes mosi_i only while SCK is low. It issues each bus access as a single-cycle strobe. Master-mode stimulus loops mosi_o back into miso_i, so received bytes equal sent bytes by construction of the bench.

// File: rtl/spix_pkg.sv
package spix_pkg;
  localparam int unsigned BUS_AW = 2;

  localparam logic [BUS_AW-1:0] A_CTRL = 2'd0;
  localparam logic [BUS_AW-1:0] A_STAT = 2'd1;
  localparam logic [BUS_AW-1:0] A_DATA = 2'd2;
  localparam logic [BUS_AW-1:0] A_PAD  = 2'd3;

  // status bit positions
  localparam int unsigned ST_DONE  = 7;
  localparam int unsigned ST_WCOL  = 6;
  localparam int unsigned ST_FAULT = 4;
  localparam int unsigned ST_MFOFF = 3;

  // control register upper nibble, bit 7 first
  typedef struct packed {
    logic ss_drive;
    logic enable;
    logic irq_en;
    logic master;
  } ctrl_t;

  typedef enum logic [1:0] {
    SS_SEL_IN   = 2'd0,
    SS_FAULT_IN = 2'd1,
    SS_AUTO_OUT = 2'd2,
    SS_SOFT_PAD = 2'd3
  } ss_role_t;
endpackage

// File: rtl/spix_sync.sv
module spix_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{INIT}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spix_regs.sv
module spix_regs
  import spix_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              irq_global_en,
  input  logic              mode_fault,
  input  logic              xfer_busy,
  input  logic              xfer_done,
  input  logic [DW-1:0]     rx_byte,
  output ctrl_t             ctrl_q,
  output logic              mf_off,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              tx_load,
  output logic [DW-1:0]     tx_byte,
  output logic              st_done,
  output logic              st_wcol,
  output logic              st_fault,
  output logic              irq
);
  localparam int unsigned CTRL_LO = DW - $bits(ctrl_t);

  logic            wr_ctrl, wr_stat, wr_data, wr_pad;
  logic            collide;
  logic [DW-1:0]   rd_mux;
  logic [DW-1:0]   stat_word;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_pad  = bus_wr && (bus_addr == A_PAD);

  // a data write is either accepted into the shifter or counted as a collision
  assign collide = wr_data &&  xfer_busy;
  assign tx_load = wr_data && !xfer_busy;
  assign tx_byte = bus_wdata;

  always_comb begin
    stat_word            = '0;
    stat_word[ST_DONE]   = st_done;
    stat_word[ST_WCOL]   = st_wcol;
    stat_word[ST_FAULT]  = st_fault;
    stat_word[ST_MFOFF]  = mf_off;
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  rd_mux = {ctrl_q, {CTRL_LO{1'b0}}};
      A_STAT:  rd_mux = stat_word;
      A_DATA:  rd_mux = rx_byte;
      default: rd_mux = {{(DW-2){1'b0}}, pad_oe, pad_out};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      mf_off    <= 1'b0;
      pad_out   <= 1'b0;
      pad_oe    <= 1'b0;
      st_done   <= 1'b0;
      st_wcol   <= 1'b0;
      st_fault  <= 1'b0;
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[DW-1:CTRL_LO]);
      // hardware shutdown on a fault overrides a software write in the same cycle
      if (mode_fault) begin
        ctrl_q.master <= 1'b0;
        ctrl_q.enable <= 1'b0;
      end

      if (wr_stat) begin
        mf_off <= bus_wdata[ST_MFOFF];
        if (bus_wdata[ST_DONE])  st_done  <= 1'b0;
        if (bus_wdata[ST_WCOL])  st_wcol  <= 1'b0;
        if (bus_wdata[ST_FAULT]) st_fault <= 1'b0;
      end
      if (xfer_done)  st_done  <= 1'b1;
      if (collide)    st_wcol  <= 1'b1;
      if (mode_fault) st_fault <= 1'b1;

      if (wr_pad) begin
        pad_out <= bus_wdata[0];
        pad_oe  <= bus_wdata[1];
      end

      if (bus_rd) bus_rdata <= rd_mux;

      irq <= ctrl_q.irq_en && irq_global_en && (st_done || st_fault);
    end
  end
endmodule

// File: rtl/spix_engine.sv
module spix_engine #(
  parameter int unsigned DW  = 8,
  parameter int unsigned DIV = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          enable,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_byte,
  input  logic          miso_i,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic          ss_s,
  output logic          sck_o,
  output logic          sdo,
  output logic          m_busy,
  output logic          xfer_busy,
  output logic          done,
  output logic [DW-1:0] rx_q
);
  localparam int unsigned CW  = (DW  > 1) ? $clog2(DW)  : 1;
  localparam int unsigned DVW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0]  LAST_BIT = CW'(DW - 1);
  localparam logic [DVW-1:0] DIV_TOP  = DVW'(DIV - 1);

  logic [DW-1:0]  sh;
  logic           smp;
  logic [CW-1:0]  cnt;
  logic [DVW-1:0] div_q;
  logic           sck_q;
  logic           s_act;
  logic           sck_d;
  logic           rise_s, fall_s;

  assign rise_s = sck_s && !sck_d;
  assign fall_s = !sck_s && sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      smp    <= 1'b0;
      cnt    <= '0;
      div_q  <= '0;
      sck_q  <= 1'b0;
      m_busy <= 1'b0;
      s_act  <= 1'b0;
      sck_d  <= 1'b0;
      done   <= 1'b0;
      rx_q   <= '0;
    end else begin
      done  <= 1'b0;
      sck_d <= sck_s;
      if (!enable) begin
        m_busy <= 1'b0;
        s_act  <= 1'b0;
        cnt    <= '0;
        sck_q  <= 1'b0;
        div_q  <= '0;
      end else if (master) begin
        s_act <= 1'b0;
        if (!m_busy) begin
          sck_q <= 1'b0;
          if (tx_load) begin
            sh     <= tx_byte;
            m_busy <= 1'b1;
            cnt    <= '0;
            div_q  <= '0;
          end
        end else if (div_q == DIV_TOP) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            smp   <= miso_i;
          end else begin
            sck_q <= 1'b0;
            sh    <= {sh[DW-2:0], smp};
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              m_busy <= 1'b0;
              done   <= 1'b1;
              rx_q   <= {sh[DW-2:0], smp};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end else begin
        m_busy <= 1'b0;
        sck_q  <= 1'b0;
        if (tx_load) sh <= tx_byte;
        if (ss_s) begin
          s_act <= 1'b0;
          cnt   <= '0;
        end else begin
          if (rise_s) begin
            smp   <= mosi_s;
            s_act <= 1'b1;
          end
          if (fall_s && s_act) begin
            sh  <= {sh[DW-2:0], smp};
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              s_act <= 1'b0;
              done  <= 1'b1;
              rx_q  <= {sh[DW-2:0], smp};
            end
          end
        end
      end
    end
  end

  assign sck_o     = sck_q;
  assign sdo       = sh[DW-1];
  assign xfer_busy = m_busy || s_act;
endmodule

// File: rtl/spix_pads.sv
module spix_pads
  import spix_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic master,
  input  logic enable,
  input  logic ss_drive,
  input  logic mf_off,
  input  logic pad_out,
  input  logic pad_oe,
  input  logic m_busy,
  input  logic ss_s,
  output logic mode_fault,
  output logic ss_o,
  output logic ss_oe,
  output logic sck_oe,
  output logic mosi_oe,
  output logic miso_oe
);
  ss_role_t role;

  always_comb begin
    if (!master)       role = SS_SEL_IN;
    else if (!mf_off)  role = SS_FAULT_IN;
    else if (ss_drive) role = SS_AUTO_OUT;
    else               role = SS_SOFT_PAD;
  end

  assign mode_fault = (role == SS_FAULT_IN) && enable && !ss_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_o    <= 1'b1;
      ss_oe   <= 1'b0;
      sck_oe  <= 1'b0;
      mosi_oe <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      unique case (role)
        SS_AUTO_OUT: begin ss_oe <= 1'b1;   ss_o <= !m_busy; end
        SS_SOFT_PAD: begin ss_oe <= pad_oe; ss_o <= pad_out; end
        default:     begin ss_oe <= 1'b0;   ss_o <= 1'b1;    end
      endcase
      sck_oe  <= master && enable;
      mosi_oe <= master && enable;
      miso_oe <= !master && enable && !ss_s;
    end
  end
endmodule

// File: rtl/spix_top.sv
module spix_top
  import spix_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned DIV         = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              irq_global_en,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_i,
  output logic              ss_o,
  output logic              ss_oe
);
  // synchronizer lanes: {select, mosi, sck}; select idles high
  localparam int unsigned       NLANE     = 3;
  localparam logic [NLANE-1:0]  LANE_INIT = 3'b100;

  logic [NLANE-1:0] pins_s;
  logic             sck_s, mosi_s, ss_s;
  ctrl_t            ctrl_q;
  logic             mf_off, pad_out, pad_oe;
  logic             tx_load;
  logic [DW-1:0]    tx_byte, rx_byte;
  logic             m_busy, xfer_busy, xfer_done, mode_fault;
  logic             st_done, st_wcol, st_fault;
  logic             sdo;

  spix_sync #(.WIDTH(NLANE), .STAGES(SYNC_STAGES), .INIT(LANE_INIT)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ss_i, mosi_i, sck_i}),
    .q   (pins_s)
  );
  assign {ss_s, mosi_s, sck_s} = pins_s;

  spix_regs #(.DW(DW)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .irq_global_en (irq_global_en),
    .mode_fault    (mode_fault),
    .xfer_busy     (xfer_busy),
    .xfer_done     (xfer_done),
    .rx_byte       (rx_byte),
    .ctrl_q        (ctrl_q),
    .mf_off        (mf_off),
    .pad_out       (pad_out),
    .pad_oe        (pad_oe),
    .tx_load       (tx_load),
    .tx_byte       (tx_byte),
    .st_done       (st_done),
    .st_wcol       (st_wcol),
    .st_fault      (st_fault),
    .irq           (irq)
  );

  spix_engine #(.DW(DW), .DIV(DIV)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .master    (ctrl_q.master),
    .enable    (ctrl_q.enable),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .miso_i    (miso_i),
    .sck_s     (sck_s),
    .mosi_s    (mosi_s),
    .ss_s      (ss_s),
    .sck_o     (sck_o),
    .sdo       (sdo),
    .m_busy    (m_busy),
    .xfer_busy (xfer_busy),
    .done      (xfer_done),
    .rx_q      (rx_byte)
  );

  spix_pads u_pads (
    .clk        (clk),
    .rst        (rst),
    .master     (ctrl_q.master),
    .enable     (ctrl_q.enable),
    .ss_drive   (ctrl_q.ss_drive),
    .mf_off     (mf_off),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .m_busy     (m_busy),
    .ss_s       (ss_s),
    .mode_fault (mode_fault),
    .ss_o       (ss_o),
    .ss_oe      (ss_oe),
    .sck_oe     (sck_oe),
    .mosi_oe    (mosi_oe),
    .miso_oe    (miso_oe)
  );

  assign mosi_o = sdo;
  assign miso_o = sdo;
endmodule

// File: rtl/spix_checker.sv
module spix_checker
  import spix_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              wcol_clr,
  input logic              irq_global_en,
  input logic              irq,
  input logic              ss_o,
  input logic              ss_oe,
  input logic              c_master,
  input logic              c_enable,
  input logic              c_drive,
  input logic              c_irq_en,
  input logic              mf_off,
  input logic              m_busy,
  input logic              xfer_busy,
  input logic              mode_fault,
  input logic              st_wcol,
  input logic              st_fault
);
  // R2: outside master mode the select pad is never driven
  a_r2_slave_ss_in: assert property (@(posedge clk) disable iff (rst)
    !c_master |=> !ss_oe);

  // R3: automatic select is low while the master shifts
  a_r3_auto_ss_low: assert property (@(posedge clk) disable iff (rst)
    (c_master && mf_off && c_drive && m_busy) |=> (ss_oe && !ss_o));

  // R5: fault shuts the master down and latches the flag
  a_r5_fault_shutdown: assert property (@(posedge clk) disable iff (rst)
    mode_fault |=> (!c_master && !c_enable && st_fault));

  // R5: no fault is taken while checking is switched off
  a_r5_fault_gated: assert property (@(posedge clk) disable iff (rst)
    mf_off |-> !mode_fault);

  // R8 / R9: a data write during a byte latches the collision flag
  a_r8_wcol_set: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DATA && xfer_busy) |=> st_wcol);

  // R10: collision flag only drops on an explicit clear write
  a_r10_wcol_sticky: assert property (@(posedge clk) disable iff (rst)
    (st_wcol && !(bus_wr && bus_addr == A_STAT && wcol_clr)) |=> st_wcol);

  // R6: interrupt follows a pending fault when both gates are open
  a_r6_irq_on_fault: assert property (@(posedge clk) disable iff (rst)
    (st_fault && c_irq_en && irq_global_en) |=> irq);

  // R6: global gate closed means no request
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !irq_global_en |=> !irq);
endmodule

bind spix_top spix_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .wcol_clr      (bus_wdata[spix_pkg::ST_WCOL]),
  .irq_global_en (irq_global_en),
  .irq           (irq),
  .ss_o          (ss_o),
  .ss_oe         (ss_oe),
  .c_master      (ctrl_q.master),
  .c_enable      (ctrl_q.enable),
  .c_drive       (ctrl_q.ss_drive),
  .c_irq_en      (ctrl_q.irq_en),
  .mf_off        (mf_off),
  .m_busy        (m_busy),
  .xfer_busy     (xfer_busy),
  .mode_fault    (mode_fault),
  .st_wcol       (st_wcol),
  .st_fault      (st_fault)
);

// File: tb/sim_spix_top.sv
`timescale 1ns/1ps
module sim_spix_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_global_en = 1'b0;
  logic       irq;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_i = 1'b1;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;
  logic       loop_en = 1'b0;
  logic       miso_i;

  always #2.5 clk = ~clk;

  assign miso_i = loop_en ? mosi_o : 1'b0;

  spix_top u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_global_en(irq_global_en),
    .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o),
    .miso_oe(miso_oe), .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  int n_vec = 0;
  int n_err = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pend = 1'b0;
  logic [7:0] cap_m = 8'h00;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: R11 read data is due one cycle after the strobe
  always @(posedge clk) rd_pend <= bus_rd;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  // master bit collector, sampled at each SCK rise
  always @(posedge sck_o) cap_m <= {cap_m[6:0], mosi_o};

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic slave_byte(input logic [7:0] mo, input bit collide, output logic [7:0] cap);
    cap = 8'h00;
    for (int i = 0; i < 8; i++) begin
      mosi_i = mo[7-i];
      wait_clk(8);
      cap = {cap[6:0], miso_o};
      sck_i = 1'b1;
      wait_clk(8);
      sck_i = 1'b0;
      if (collide && i == 3) begin
        chk("R2 miso_oe while selected", {7'd0, miso_oe}, 8'h01);
        bus_write(2'd2, 8'hFF);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [7:0] scap;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);

    // R1 reset state (read path also covers R11)
    expect_rd(2'd0, 8'h00, "R1/R11 ctrl");
    expect_rd(2'd1, 8'h00, "R1 status");
    expect_rd(2'd2, 8'h00, "R1 data");
    expect_rd(2'd3, 8'h00, "R1 pad");
    chk("R1 pads", {3'd0, ss_oe, sck_oe, irq, 1'b0, ss_o}, 8'h01);

    // R4 software-owned pad in master mode
    bus_write(2'd0, 8'h10);
    bus_write(2'd1, 8'h08);
    bus_write(2'd3, 8'h03);
    wait_clk(3);
    chk("R4 pad oe=1 val=1", {6'd0, ss_oe, ss_o}, 8'h03);
    bus_write(2'd3, 8'h02);
    wait_clk(3);
    chk("R4 pad oe=1 val=0", {6'd0, ss_oe, ss_o}, 8'h02);
    expect_rd(2'd3, 8'h02, "R4 pad readback");

    // R3 auto select, R7 master byte, R8 collision
    loop_en = 1'b1;
    bus_write(2'd0, 8'hD0);
    wait_clk(3);
    chk("R3 idle select high", {6'd0, ss_oe, ss_o}, 8'h03);
    bus_write(2'd2, 8'hA5);
    wait_clk(4);
    chk("R3 select low during byte", {6'd0, ss_oe, ss_o}, 8'h02);
    wait_clk(4);
    bus_write(2'd2, 8'h3C);
    wait_clk(60);
    chk("R3 select high after byte", {6'd0, ss_oe, ss_o}, 8'h03);
    chk("R7 mosi MSB first", cap_m, 8'hA5);
    expect_rd(2'd2, 8'hA5, "R8 byte kept, write dropped");
    expect_rd(2'd1, 8'hC8, "R8 done+wcol set");

    // R10 sticky flags
    bus_write(2'd1, 8'h08);
    expect_rd(2'd1, 8'hC8, "R10 zero write keeps flags");
    bus_write(2'd1, 8'h48);
    expect_rd(2'd1, 8'h88, "R10 clear wcol only");
    bus_write(2'd1, 8'h88);
    expect_rd(2'd1, 8'h08, "R10 clear done");

    // R6 interrupt gating, R7 second pattern
    bus_write(2'd0, 8'hF0);
    bus_write(2'd2, 8'h5A);
    wait_clk(60);
    chk("R6 irq gated by global", {7'd0, irq}, 8'h00);
    irq_global_en = 1'b1;
    wait_clk(3);
    chk("R6 irq on done", {7'd0, irq}, 8'h01);
    expect_rd(2'd2, 8'h5A, "R7 loopback byte");
    bus_write(2'd1, 8'h88);
    wait_clk(3);
    chk("R6 irq drops after clear", {7'd0, irq}, 8'h00);

    // R5 mode fault
    loop_en = 1'b0;
    ss_i = 1'b0;
    bus_write(2'd0, 8'h70);
    wait_clk(6);
    expect_rd(2'd0, 8'h70, "R5 no fault when check off");
    bus_write(2'd1, 8'h00);
    wait_clk(6);
    expect_rd(2'd0, 8'h20, "R5 master+enable cleared");
    expect_rd(2'd1, 8'h10, "R5 fault flag");
    chk("R5 irq on fault", {7'd0, irq}, 8'h01);
    chk("R2 select released", {7'd0, ss_oe}, 8'h00);
    ss_i = 1'b1;
    bus_write(2'd1, 8'h10);
    expect_rd(2'd1, 8'h00, "R10 clear fault");

    // R9 / R12 slave
    bus_write(2'd0, 8'h40);
    bus_write(2'd2, 8'h96);
    wait_clk(4);
    expect_rd(2'd1, 8'h00, "R9 idle preload no collision");
    ss_i = 1'b0;
    wait_clk(4);
    slave_byte(8'h3C, 1'b1, scap);
    wait_clk(10);
    chk("R9 miso carries preload", scap, 8'h96);
    chk("R2 select pad undriven", {7'd0, ss_oe}, 8'h00);
    expect_rd(2'd2, 8'h3C, "R12 slave rx byte");
    expect_rd(2'd1, 8'hC0, "R9 wcol + R12 done");
    ss_i = 1'b1;
    wait_clk(4);
    chk("R2 miso_oe off when deselected", {7'd0, miso_oe}, 8'h00);

    // R2 deselected slave ignores SCK
    bus_write(2'd1, 8'hC0);
    slave_byte(8'hFF, 1'b0, scap);
    wait_clk(10);
    expect_rd(2'd1, 8'h00, "R2 no done while deselected");
    expect_rd(2'd2, 8'h3C, "R2 rx buffer untouched");

    wait_clk(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule